// File: doc/BRIEF.md
# Writeback-to-Execute Operand Bypass

This unit sits in the execute stage of a three-stage 32-bit integer pipeline whose stages are fetch/decode, execute and writeback. It supplies both source operands of the instruction in execute. For each operand it compares the source register index with the destination of the instruction now in writeback. If they match and that instruction will really write a register, the operand is taken from writeback instead of from the register file.

The forwarded value depends on the writeback instruction. For a load it is the data just returned from memory. For any other instruction it is the ALU result held in the writeback register. The register file is read in the same stage that uses the operands, so an instruction that needs a load result in the very next slot gets it through this path with no bubble.

Register index zero always reads as zero. A flushed writeback instruction never forwards. The second operand feeds the ALU and is also the data carried forward for stores. The unit has no clock. The register file, ALU and memory are outside it.

Top module: `fwd_bypass_unit`

## Requirements
- R1: When `wb_reg_we`=1, `wb_flushed`=0, `wb_is_load`=0 and `wb_rd_idx` equals a nonzero `ex_rs1_idx`, `ex_op1_data` equals `wb_alu_result`.
- R2: Under the same match with `wb_is_load`=1, `ex_op1_data` equals `wb_load_data`.
- R3: When the writeback destination differs from the source index, the operand equals its register-file read port (`rf_rd1_data` for operand 1, `rf_rd2_data` for operand 2).
- R4: A source index of 0 yields an operand value of 0, even when the writeback destination is also 0 and register write is enabled.
- R5: With `wb_flushed`=1, no operand is forwarded and both operands come from the register file.
- R6: With `wb_reg_we`=0, no operand is forwarded, even when the indices match.
- R7: Operand 2 follows the rules of R1 to R6 against `ex_rs2_idx`, and `ex_store_data` always equals `ex_op2_data`.
- R8: The two operands resolve independently: both may forward from the same writeback destination in one cycle.
- R9: The outputs are purely combinational. A change of input appears at the outputs in the same cycle, without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | 5 | First source register index of the instruction in execute |
| ex_rs2_idx | input | 5 | Second source register index of the instruction in execute |
| rf_rd1_data | input | 32 | Register-file read data for the first source |
| rf_rd2_data | input | 32 | Register-file read data for the second source |
| wb_reg_we | input | 1 | Writeback instruction writes a register |
| wb_rd_idx | input | 5 | Destination register index of the writeback instruction |
| wb_is_load | input | 1 | Writeback instruction is a load (its memory read is enabled) |
| wb_flushed | input | 1 | Writeback instruction has been flushed |
| wb_load_data | input | 32 | Data returned from memory for the writeback load |
| wb_alu_result | input | 32 | ALU result held in the writeback register |
| ex_op1_data | output | 32 | Resolved first operand |
| ex_op2_data | output | 32 | Resolved second operand to the ALU |
| ex_store_data | output | 32 | Store data, which is the resolved second operand |

## Verification
Every result of this unit is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The bench changes the inputs just after a falling clock edge. It samples the outputs one nanosecond later, well before the next rising edge, so no check depends on edge ordering. For R9 the bench changes the inputs a second time inside one clock period and checks the new value before any further edge.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand source chosen for one execute-stage operand.
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'd0,
    SRC_ALU     = 2'd1,
    SRC_LOAD    = 2'd2,
    SRC_ZERO    = 2'd3
  } src_sel_e;

endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect
  import fwd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] src_idx,
  input  logic             wb_reg_we,
  input  logic             wb_flushed,
  input  logic             wb_is_load,
  input  logic [IDX_W-1:0] wb_rd_idx,
  output src_sel_e         sel
);

  logic idx_is_zero;
  logic idx_match;
  logic wb_live;

  always_comb begin
    idx_is_zero = (src_idx == '0);
    idx_match   = (src_idx == wb_rd_idx);
    wb_live     = wb_reg_we & ~wb_flushed;
  end

  // The zero register has the highest priority, then a live writeback match.
  always_comb begin
    if (idx_is_zero) begin
      sel = SRC_ZERO;
    end else if (wb_live && idx_match) begin
      sel = wb_is_load ? SRC_LOAD : SRC_ALU;
    end else begin
      sel = SRC_REGFILE;
    end
  end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
  import fwd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  src_sel_e        sel,
  input  logic [XLEN-1:0] rf_data,
  input  logic [XLEN-1:0] alu_data,
  input  logic [XLEN-1:0] load_data,
  output logic [XLEN-1:0] operand
);

  always_comb begin
    unique case (sel)
      SRC_ALU:  operand = alu_data;
      SRC_LOAD: operand = load_data;
      SRC_ZERO: operand = '0;
      default:  operand = rf_data;
    endcase
  end

endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit
  import fwd_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_rs1_idx,
  input  logic [IDX_W-1:0] ex_rs2_idx,
  input  logic [XLEN-1:0]  rf_rd1_data,
  input  logic [XLEN-1:0]  rf_rd2_data,
  input  logic             wb_reg_we,
  input  logic [IDX_W-1:0] wb_rd_idx,
  input  logic             wb_is_load,
  input  logic             wb_flushed,
  input  logic [XLEN-1:0]  wb_load_data,
  input  logic [XLEN-1:0]  wb_alu_result,
  output logic [XLEN-1:0]  ex_op1_data,
  output logic [XLEN-1:0]  ex_op2_data,
  output logic [XLEN-1:0]  ex_store_data
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
  logic [NUM_SRC-1:0][XLEN-1:0]  rf_data;
  logic [NUM_SRC-1:0][XLEN-1:0]  opnd;
  src_sel_e                      sel [NUM_SRC];

  always_comb begin
    src_idx[0] = ex_rs1_idx;
    src_idx[1] = ex_rs2_idx;
    rf_data[0] = rf_rd1_data;
    rf_data[1] = rf_rd2_data;
  end

  // Each source resolves on its own, so both may hit the same destination.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_hit_detect #(
      .IDX_W (IDX_W)
    ) hit_i (
      .src_idx    (src_idx[g]),
      .wb_reg_we  (wb_reg_we),
      .wb_flushed (wb_flushed),
      .wb_is_load (wb_is_load),
      .wb_rd_idx  (wb_rd_idx),
      .sel        (sel[g])
    );

    fwd_operand_mux #(
      .XLEN (XLEN)
    ) mux_i (
      .sel       (sel[g]),
      .rf_data   (rf_data[g]),
      .alu_data  (wb_alu_result),
      .load_data (wb_load_data),
      .operand   (opnd[g])
    );
  end

  always_comb begin
    ex_op1_data   = opnd[0];
    ex_op2_data   = opnd[1];
    ex_store_data = opnd[1];
  end

endmodule

// File: rtl/fwd_bypass_unit_chk.sv
module fwd_bypass_unit_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] ex_rs1_idx,
  input logic [IDX_W-1:0] ex_rs2_idx,
  input logic [XLEN-1:0]  rf_rd1_data,
  input logic [XLEN-1:0]  rf_rd2_data,
  input logic             wb_reg_we,
  input logic [IDX_W-1:0] wb_rd_idx,
  input logic             wb_is_load,
  input logic             wb_flushed,
  input logic [XLEN-1:0]  wb_load_data,
  input logic [XLEN-1:0]  wb_alu_result,
  input logic [XLEN-1:0]  ex_op1_data,
  input logic [XLEN-1:0]  ex_op2_data
);

  logic live;
  logic hit1;
  logic hit2;

  always_comb begin
    live = wb_reg_we && !wb_flushed;
    hit1 = live && (ex_rs1_idx != '0) && (wb_rd_idx == ex_rs1_idx);
    hit2 = live && (ex_rs2_idx != '0) && (wb_rd_idx == ex_rs2_idx);
  end

  always_comb begin
    if (ex_rs1_idx == '0) begin
      AST_ZERO_SRC1: assert (ex_op1_data == '0); // R4
    end
    if (ex_rs2_idx == '0) begin
      AST_ZERO_SRC2: assert (ex_op2_data == '0); // R4
    end
    if (hit1 && !wb_is_load) begin
      AST_ALU_FWD_OP1: assert (ex_op1_data == wb_alu_result); // R1
    end
    if (hit1 && wb_is_load) begin
      AST_LOAD_FWD_OP1: assert (ex_op1_data == wb_load_data); // R2
    end
    if (wb_flushed && ex_rs1_idx != '0) begin
      AST_FLUSH_NO_FWD: assert (ex_op1_data == rf_rd1_data); // R5
    end
    if (!wb_reg_we && ex_rs2_idx != '0) begin
      AST_NOWE_NO_FWD: assert (ex_op2_data == rf_rd2_data); // R6
    end
    if (ex_rs1_idx != '0 && wb_rd_idx != ex_rs1_idx) begin
      AST_MISS_REGFILE: assert (ex_op1_data == rf_rd1_data); // R3
    end
    if (hit2) begin
      AST_OP2_FWD: assert (ex_op2_data == (wb_is_load ? wb_load_data : wb_alu_result)); // R7
    end
  end

endmodule

bind fwd_bypass_unit fwd_bypass_unit_chk #(
  .XLEN  (XLEN),
  .IDX_W (IDX_W)
) chk_i (
  .ex_rs1_idx    (ex_rs1_idx),
  .ex_rs2_idx    (ex_rs2_idx),
  .rf_rd1_data   (rf_rd1_data),
  .rf_rd2_data   (rf_rd2_data),
  .wb_reg_we     (wb_reg_we),
  .wb_rd_idx     (wb_rd_idx),
  .wb_is_load    (wb_is_load),
  .wb_flushed    (wb_flushed),
  .wb_load_data  (wb_load_data),
  .wb_alu_result (wb_alu_result),
  .ex_op1_data   (ex_op1_data),
  .ex_op2_data   (ex_op2_data)
);

// File: tb/fwd_bypass_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_bypass_unit_tb_top;

  logic        clk;
  logic [4:0]  rs1, rs2, rd;
  logic [31:0] rf1, rf2, ld, alu;
  logic        we, isld, fl;
  logic [31:0] op1, op2, st;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  fwd_bypass_unit dut_i (
    .ex_rs1_idx    (rs1),
    .ex_rs2_idx    (rs2),
    .rf_rd1_data   (rf1),
    .rf_rd2_data   (rf2),
    .wb_reg_we     (we),
    .wb_rd_idx     (rd),
    .wb_is_load    (isld),
    .wb_flushed    (fl),
    .wb_load_data  (ld),
    .wb_alu_result (alu),
    .ex_op1_data   (op1),
    .ex_op2_data   (op2),
    .ex_store_data (st)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                       input logic w, input logic l, input logic f);
    @(negedge clk);
    rs1 = a; rs2 = b; rd = d; we = w; isld = l; fl = f;
    rf1 = 32'h1111_0001; rf2 = 32'h2222_0002;
    ld = 32'hDEAD_0003; alu = 32'hA1A1_0004;
    #1;
  endtask

  task automatic t_idle;
    drive(5'd3, 5'd5, 5'd0, 1'b0, 1'b0, 1'b0);
    check("R3 idle op1", op1, 32'h1111_0001);
    check("R3 idle op2", op2, 32'h2222_0002);
  endtask

  task automatic t_alu_fwd;
    drive(5'd7, 5'd9, 5'd7, 1'b1, 1'b0, 1'b0);
    check("R1 alu op1", op1, 32'hA1A1_0004);
    check("R3 op2 no match", op2, 32'h2222_0002);
  endtask

  task automatic t_load_fwd;
    drive(5'd12, 5'd1, 5'd12, 1'b1, 1'b1, 1'b0);
    check("R2 load op1", op1, 32'hDEAD_0003);
  endtask

  task automatic t_op2;
    drive(5'd4, 5'd20, 5'd20, 1'b1, 1'b0, 1'b0);
    check("R7 alu op2", op2, 32'hA1A1_0004);
    check("R7 store alu", st, 32'hA1A1_0004);
    check("R7 op1 untouched", op1, 32'h1111_0001);
    drive(5'd4, 5'd20, 5'd20, 1'b1, 1'b1, 1'b0);
    check("R7 load op2", op2, 32'hDEAD_0003);
    check("R7 store load", st, 32'hDEAD_0003);
  endtask

  task automatic t_both;
    drive(5'd31, 5'd31, 5'd31, 1'b1, 1'b1, 1'b0);
    check("R8 both op1", op1, 32'hDEAD_0003);
    check("R8 both op2", op2, 32'hDEAD_0003);
  endtask

  task automatic t_zero;
    drive(5'd0, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0);
    check("R4 zero op1", op1, 32'h0);
    check("R4 zero op2", op2, 32'h0);
    check("R4 zero store", st, 32'h0);
  endtask

  task automatic t_flush;
    drive(5'd6, 5'd6, 5'd6, 1'b1, 1'b1, 1'b1);
    check("R5 flush op1", op1, 32'h1111_0001);
    check("R5 flush op2", op2, 32'h2222_0002);
  endtask

  task automatic t_nowe;
    drive(5'd8, 5'd8, 5'd8, 1'b0, 1'b1, 1'b0);
    check("R6 nowe op1", op1, 32'h1111_0001);
    check("R6 nowe op2", op2, 32'h2222_0002);
  endtask

  task automatic t_miss;
    drive(5'd10, 5'd11, 5'd13, 1'b1, 1'b0, 1'b0);
    check("R3 miss op1", op1, 32'h1111_0001);
    check("R3 miss op2", op2, 32'h2222_0002);
  endtask

  task automatic t_comb;
    drive(5'd2, 5'd3, 5'd2, 1'b1, 1'b0, 1'b0);
    check("R9 first", op1, 32'hA1A1_0004);
    alu = 32'h0BAD_F00D;
    #1;
    check("R9 same cycle alu", op1, 32'h0BAD_F00D);
    rd = 5'd3;
    #1;
    check("R9 same cycle op1 back", op1, 32'h1111_0001);
    check("R9 same cycle op2", op2, 32'h0BAD_F00D);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rs1 = '0; rs2 = '0; rd = '0; we = 1'b0; isld = 1'b0; fl = 1'b0;
    rf1 = '0; rf2 = '0; ld = '0; alu = '0;
    repeat (2) @(posedge clk);
    t_idle;
    t_alu_fwd;
    t_load_fwd;
    t_op2;
    t_both;
    t_zero;
    t_flush;
    t_nowe;
    t_miss;
    t_comb;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule